// File: doc/BRIEF.md
# Scalar Operand Resolver

This block turns the operand selector of a scalar instruction into data, and steers a scalar result to where it belongs. It owns the scalar register storage for one wavefront and the 64-bit execution mask. One operation is offered per cycle. A read returns a 32-bit or 64-bit value one cycle later. A write lands on the clock edge that accepts it.

A selector can name one of several kinds of source or destination:
- a general scalar register, placed at the wavefront's scalar base;
- one of three special registers (condition pair, scratch high, scratch low), placed just below the reserved-register count;
- either half of the execution mask, or the whole mask;
- one of nine inline constants;
- the literal word carried by the instruction.

Inline float constants follow the operand width: an IEEE single for one word, an IEEE double for two words. Illegal combinations of selector and width raise a one-cycle error pulse, and then nothing is changed.

Top module: `sop_unit`

## Requirements
- R1: After synchronous reset, `exec_mask` is all ones and `rd_valid` and `err` are low.
- R2: Selectors 0x00 to 0x5F name general registers.
  - Word w maps to physical word `sreg_base + sel + w`.
  - A two-word access (`op_nwords`=2) uses two consecutive words, with the lower address in bits 31:0.
  - A one-word read returns zero in bits 63:32.
  - Read data and `rd_valid` appear in the cycle after the operation.
- R3: A legal register write takes its data from `load_data` when `op_is_load` is 1, and from `result` otherwise.
- R4: Special-register selectors map relative to the reserved count `rsv_count`, plus the word offset:
  - 0x60 (condition pair) maps to `sreg_base + rsv_count - 2`;
  - 0x61 (scratch high) maps to `sreg_base + rsv_count - 3`;
  - 0x62 (scratch low, one word only) maps to `sreg_base + rsv_count - 4`.
- R5: Reading the execution mask:
  - 0x64 with one word returns mask bits 31:0;
  - 0x64 with two words returns all 64 bits;
  - 0x65 (one word only) returns bits 63:32.
- R6: Writing the execution mask always takes `result`:
  - 0x64 with one word replaces bits 31:0 only;
  - 0x64 with two words replaces all 64 bits;
  - 0x65 replaces bits 63:32 with `result[31:0]`.
- R7: Selectors 0x70 to 0x77 read +0.5, -0.5, +1, -1, +2, -2, +4 and -4, in that order. Each is an IEEE single for one word and an IEEE double for two words.
- R8: Selector 0x78 reads 0x3E22F983 for one word and 0x3FC45F306DC9C882 for two words.
- R9: Selectors 0x7C, 0x7D and 0x7E read `lit_word`. Each is a one-word-only selector.
- R10: The following raise `err` for one cycle, with no register or mask change and no `rd_valid`:
  - a width other than 1 or 2;
  - an undefined selector;
  - a two-word access on a one-word-only selector;
  - a write to a constant or literal selector;
  - a reserved count too small for the special register named;
  - any word falling outside the storage.
- R11: `rd_valid` pulses exactly for legal reads. It never coincides with `err`, and a write never produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_nwords | input | 2 | Operand width in 32-bit words |
| op_sel | input | 8 | Operand selector |
| op_is_load | input | 1 | Write data comes from load return |
| lit_word | input | 32 | Literal attached to the instruction |
| result | input | 64 | Computed result for writes |
| load_data | input | 64 | Load-return data for writes |
| sreg_base | input | 7 | Wavefront scalar base word |
| rsv_count | input | 7 | Reserved scalar register count |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| err | output | 1 | Illegal operation pulse |
| exec_mask | output | 64 | Execution mask |

## Verification
The hardest case to reach is a two-word access that starts on an odd physical word. In that case the two halves come from opposite storage banks and must be swapped back into order. Random bases and selectors make this happen often.

The remapped special registers are also hard to reach. They only show where they landed when the same words are read back through plain register selectors. Directed sequences write through the special selector and then read the expected physical words by their ordinary numbers. Boundary cases cover a reserved count that is too small, and a wide access whose second word falls past the end of storage.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int NSEL_GPR = 96;

  localparam logic [7:0] SEL_VCC    = 8'h60;
  localparam logic [7:0] SEL_SCR_HI = 8'h61;
  localparam logic [7:0] SEL_SCR_LO = 8'h62;
  localparam logic [7:0] SEL_XLO    = 8'h64;
  localparam logic [7:0] SEL_XHI    = 8'h65;
  localparam logic [7:0] SEL_PI     = 8'h78;
  localparam logic [7:0] SEL_LIT0   = 8'h7C;
  localparam logic [7:0] SEL_LIT2   = 8'h7E;

  localparam logic [31:0] PI_S = 32'h3E22F983;
  localparam logic [63:0] PI_D = 64'h3FC45F306DC9C882;

  typedef enum logic [3:0] {
    K_GPR, K_VCC, K_SHI, K_SLO, K_XLO, K_XHI, K_CONST, K_PI, K_LIT, K_BAD
  } sel_kind_e;

  function automatic sel_kind_e classify(input logic [7:0] sel);
    if (sel < 8'(NSEL_GPR)) return K_GPR;
    case (sel)
      SEL_VCC:    return K_VCC;
      SEL_SCR_HI: return K_SHI;
      SEL_SCR_LO: return K_SLO;
      SEL_XLO:    return K_XLO;
      SEL_XHI:    return K_XHI;
      SEL_PI:     return K_PI;
      default: begin
        if (sel[7:3] == 5'b01110) return K_CONST;
        if (sel >= SEL_LIT0 && sel <= SEL_LIT2) return K_LIT;
        return K_BAD;
      end
    endcase
  endfunction

  // magnitudes 0.5,1,2,4 by idx[2:1]; idx[0] is the sign
  function automatic logic [63:0] inline_const(input logic [2:0] idx,
                                               input logic wide);
    logic [7:0]  es;
    logic [10:0] ed;
    es = 8'd126 + 8'(idx[2:1]);
    ed = 11'd1022 + 11'(idx[2:1]);
    if (wide) return {idx[0], ed, 52'd0};
    return {32'd0, idx[0], es, 23'd0};
  endfunction
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int PHYS_W = $clog2(DEPTH)
) (
  input  logic [7:0]        sel,
  input  logic [1:0]        nwords,
  input  logic              write,
  input  logic [PHYS_W-1:0] base,
  input  logic [PHYS_W-1:0] rsv,
  output sel_kind_e         kind,
  output logic              is_reg,
  output logic              wide,
  output logic [PHYS_W-1:0] addr,
  output logic              bad
);
  localparam int FW = PHYS_W + 2;

  logic [FW-1:0] b_x, r_x, full, off;
  logic          under, sel_bad, width_bad;

  always_comb begin
    kind      = classify(sel);
    wide      = (nwords == 2'd2);
    width_bad = !(nwords == 2'd1 || nwords == 2'd2);
    b_x       = FW'(base);
    r_x       = FW'(rsv);
    under     = 1'b0;
    sel_bad   = 1'b0;
    is_reg    = 1'b0;
    off       = '0;

    case (kind)
      K_GPR: begin is_reg = 1'b1; off = FW'(sel); end
      K_VCC: begin is_reg = 1'b1; under = r_x < 2; off = r_x - 2; end
      K_SHI: begin is_reg = 1'b1; under = r_x < 3; off = r_x - 3; end
      K_SLO: begin is_reg = 1'b1; under = r_x < 4; off = r_x - 4; sel_bad = wide; end
      K_XHI:   sel_bad = wide;
      K_CONST, K_PI: sel_bad = write;
      K_LIT:   sel_bad = write || wide;
      K_BAD:   sel_bad = 1'b1;
      default: sel_bad = 1'b0;
    endcase

    full = b_x + off;
    addr = full[PHYS_W-1:0];
    bad  = width_bad || sel_bad || under ||
           (is_reg && ((full + FW'(wide)) >= FW'(DEPTH)));
  end
endmodule

// File: rtl/sop_bank.sv
module sop_bank #(
  parameter int ROWS  = 64,
  parameter int DW    = 32,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wd,
  output logic [DW-1:0]    q
);
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wd;
    q <= mem[row];
  end
endmodule

// File: rtl/sop_exec.sv
module sop_exec #(
  parameter int MW = 64,
  localparam int HW = MW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [HW-1:0] lo_val,
  input  logic [HW-1:0] hi_val,
  output logic [MW-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
    end else begin
      if (we_lo) mask[HW-1:0]  <= lo_val;
      if (we_hi) mask[MW-1:HW] <= hi_val;
    end
  end
endmodule

// File: rtl/sop_unit.sv
module sop_unit
  import sop_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int PHYS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_write,
  input  logic [1:0]        op_nwords,
  input  logic [7:0]        op_sel,
  input  logic              op_is_load,
  input  logic [31:0]       lit_word,
  input  logic [63:0]       result,
  input  logic [63:0]       load_data,
  input  logic [PHYS_W-1:0] sreg_base,
  input  logic [PHYS_W-1:0] rsv_count,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              err,
  output logic [63:0]       exec_mask
);
  localparam int ROWS  = DEPTH / 2;
  localparam int ROW_W = $clog2(ROWS);

  sel_kind_e         kind;
  logic              is_reg, wide, bad, legal;
  logic [PHYS_W-1:0] addr;
  logic [PHYS_W:0]   addr_nx;
  logic [63:0]       src;
  logic [31:0]       bq [2];
  logic              gpr_q, wide_q, lsb_q;
  logic [63:0]       aux_q;

  sop_decode #(.DEPTH(DEPTH), .PHYS_W(PHYS_W)) u_dec (
    .sel(op_sel), .nwords(op_nwords), .write(op_write),
    .base(sreg_base), .rsv(rsv_count),
    .kind(kind), .is_reg(is_reg), .wide(wide), .addr(addr), .bad(bad)
  );

  assign legal   = op_valid && !bad;
  assign src     = op_is_load ? load_data : result;
  assign addr_nx = (PHYS_W+1)'(addr) + 1'b1;

  // even physical words live in bank 0, odd ones in bank 1
  for (genvar j = 0; j < 2; j++) begin : g_bank
    logic             hit0;
    logic [ROW_W-1:0] row;
    logic             we;
    logic [31:0]      wd;

    assign hit0 = (addr[0] == 1'(j));
    assign row  = hit0 ? addr[PHYS_W-1:1] : addr_nx[PHYS_W:1];
    assign we   = legal && op_write && is_reg && (hit0 || wide);
    assign wd   = hit0 ? src[31:0] : src[63:32];

    sop_bank #(.ROWS(ROWS), .DW(32)) u_bank (
      .clk(clk), .we(we), .row(row), .wd(wd), .q(bq[j])
    );
  end

  logic x_lo, x_hi;
  logic [31:0] x_hi_val;
  assign x_lo     = legal && op_write && (kind == K_XLO);
  assign x_hi     = legal && op_write && ((kind == K_XHI) || (kind == K_XLO && wide));
  assign x_hi_val = (kind == K_XHI) ? result[31:0] : result[63:32];

  sop_exec #(.MW(64)) u_exec (
    .clk(clk), .rst(rst), .we_lo(x_lo), .we_hi(x_hi),
    .lo_val(result[31:0]), .hi_val(x_hi_val), .mask(exec_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      gpr_q    <= 1'b0;
      wide_q   <= 1'b0;
      lsb_q    <= 1'b0;
      aux_q    <= '0;
    end else begin
      rd_valid <= legal && !op_write;
      err      <= op_valid && bad;
      gpr_q    <= is_reg;
      wide_q   <= wide;
      lsb_q    <= addr[0];
      case (kind)
        K_XLO:   aux_q <= wide ? exec_mask : {32'd0, exec_mask[31:0]};
        K_XHI:   aux_q <= {32'd0, exec_mask[63:32]};
        K_CONST: aux_q <= inline_const(op_sel[2:0], wide);
        K_PI:    aux_q <= wide ? PI_D : {32'd0, PI_S};
        K_LIT:   aux_q <= {32'd0, lit_word};
        default: aux_q <= '0;
      endcase
    end
  end

  logic [31:0] w0, w1;
  assign w0      = lsb_q ? bq[1] : bq[0];
  assign w1      = lsb_q ? bq[0] : bq[1];
  assign rd_data = gpr_q ? (wide_q ? {w1, w0} : {32'd0, w0}) : aux_q;
endmodule

// File: rtl/sop_unit_chk.sv
module sop_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic        op_write,
  input logic [1:0]  op_nwords,
  input logic [7:0]  op_sel,
  input logic        rd_valid,
  input logic [63:0] rd_data,
  input logic        err,
  input logic [63:0] exec_mask
);
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && err));

  p_rdv_src_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(op_valid) && !$past(op_write) && !$past(rst)));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (err && !$past(rst)) |-> $stable(exec_mask));

  p_mask_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(op_valid) && $past(op_write))) |-> $stable(exec_mask));

  p_lo_keeps_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid && op_write && op_sel == 8'h64 && op_nwords == 2'd1))
      |-> (exec_mask[63:32] == $past(exec_mask[63:32])));

  p_narrow_zext_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(op_nwords) == 2'd1) |-> (rd_data[63:32] == 32'd0));
endmodule

bind sop_unit sop_unit_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_write(op_write),
  .op_nwords(op_nwords), .op_sel(op_sel), .rd_valid(rd_valid),
  .rd_data(rd_data), .err(err), .exec_mask(exec_mask)
);

// File: tb/sim_sop_unit.sv
module sim_sop_unit;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0, op_write = 1'b0, op_is_load = 1'b0;
  logic [1:0]  op_nwords = 2'd1;
  logic [7:0]  op_sel = 8'd0;
  logic [31:0] lit_word = 32'd0;
  logic [63:0] result = 64'd0, load_data = 64'd0;
  logic [6:0]  sreg_base = 7'd0, rsv_count = 7'd8;
  logic        rd_valid, err;
  logic [63:0] rd_data, exec_mask;

  int total = 0, bad = 0;
  logic [31:0] ref_mem [DEPTH];
  logic [63:0] ref_exec;

  always #(PERIOD/2) clk = ~clk;

  sop_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_write(op_write),
    .op_nwords(op_nwords), .op_sel(op_sel), .op_is_load(op_is_load),
    .lit_word(lit_word), .result(result), .load_data(load_data),
    .sreg_base(sreg_base), .rsv_count(rsv_count), .rd_valid(rd_valid),
    .rd_data(rd_data), .err(err), .exec_mask(exec_mask)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] const_val(input int idx, input logic wide);
    real v;
    logic [31:0] s;
    case (idx)
      0: begin v =  0.5; s = 32'h3F000000; end
      1: begin v = -0.5; s = 32'hBF000000; end
      2: begin v =  1.0; s = 32'h3F800000; end
      3: begin v = -1.0; s = 32'hBF800000; end
      4: begin v =  2.0; s = 32'h40000000; end
      5: begin v = -2.0; s = 32'hC0000000; end
      6: begin v =  4.0; s = 32'h40800000; end
      default: begin v = -4.0; s = 32'hC0800000; end
    endcase
    return wide ? $realtobits(v) : {32'd0, s};
  endfunction

  // one operation; expected values from the requirement text
  task automatic op(input logic wr, input logic [1:0] n, input logic [7:0] sel,
                    input logic ld, input logic [63:0] res, input logic [63:0] ldd);
    int a, off;
    logic ok, isreg, w2;
    logic [63:0] exp, srcv;
    string tag;
    ok = 1'b1; isreg = 1'b0; exp = 64'd0; a = 0; tag = "R10";
    w2 = (n == 2'd2);
    if (n != 2'd1 && n != 2'd2) ok = 1'b0;
    if (sel < 8'h60) begin
      isreg = 1'b1; off = int'(sel); tag = ld ? "R3" : "R2";
    end else if (sel >= 8'h60 && sel <= 8'h62) begin
      isreg = 1'b1; tag = "R4";
      off = int'(rsv_count) - (2 + int'(sel - 8'h60));
      if (off < 0) ok = 1'b0;
      if (sel == 8'h62 && w2) ok = 1'b0;
    end else if (sel == 8'h64) begin
      tag = wr ? "R6" : "R5";
      exp = w2 ? ref_exec : {32'd0, ref_exec[31:0]};
    end else if (sel == 8'h65) begin
      tag = wr ? "R6" : "R5";
      if (w2) ok = 1'b0;
      exp = {32'd0, ref_exec[63:32]};
    end else if (sel >= 8'h70 && sel <= 8'h77) begin
      tag = "R7"; if (wr) ok = 1'b0;
      exp = const_val(int'(sel - 8'h70), w2);
    end else if (sel == 8'h78) begin
      tag = "R8"; if (wr) ok = 1'b0;
      exp = w2 ? 64'h3FC45F306DC9C882 : 64'h3E22F983;
    end else if (sel >= 8'h7C && sel <= 8'h7E) begin
      tag = "R9"; if (wr || w2) ok = 1'b0;
      exp = {32'd0, lit_word};
    end else begin
      ok = 1'b0;
    end
    if (isreg) begin
      a = int'(sreg_base) + off;
      if (a + (w2 ? 1 : 0) >= DEPTH) ok = 1'b0;
      if (ok) exp = w2 ? {ref_mem[a+1], ref_mem[a]} : {32'd0, ref_mem[a]};
    end
    if (!ok) tag = "R10";
    srcv = ld ? ldd : res;
    if (ok && wr) begin
      if (isreg) begin
        ref_mem[a] = srcv[31:0];
        if (w2) ref_mem[a+1] = srcv[63:32];
      end else if (sel == 8'h64) begin
        ref_exec[31:0] = res[31:0];
        if (w2) ref_exec[63:32] = res[63:32];
      end else begin
        ref_exec[63:32] = res[31:0];
      end
    end
    op_valid = 1'b1; op_write = wr; op_nwords = n; op_sel = sel;
    op_is_load = ld; result = res; load_data = ldd;
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " err"}, {63'd0, err}, {63'd0, !ok});
    check({tag, "/R11 rd_valid"}, {63'd0, rd_valid}, {63'd0, ok && !wr});
    if (ok && !wr) check({tag, " data"}, rd_data, exp);
    check({tag, " exec"}, exec_mask, ref_exec);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    ref_exec = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 exec", exec_mask, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    check("R1 err", {63'd0, err}, 64'd0);

    // fill storage, one word at a time (R2)
    for (int p = 0; p < DEPTH; p++) begin
      sreg_base = (p < 96) ? 7'd0 : 7'd32;
      op(1'b1, 2'd1, 8'(p - int'(sreg_base)), 1'b0, {32'hDEAD0000, 32'(p * 32'h01010101)}, 64'd0);
    end

    // R2 odd-start wide read and write
    sreg_base = 7'd3;
    op(1'b1, 2'd2, 8'd4, 1'b0, 64'h1111_2222_3333_4444, 64'd0);
    op(1'b0, 2'd2, 8'd4, 1'b0, 64'd0, 64'd0);
    op(1'b0, 2'd1, 8'd5, 1'b0, 64'd0, 64'd0);
    // R3 load source
    op(1'b1, 2'd2, 8'd9, 1'b1, 64'hBAD0_BAD0_BAD0_BAD0, 64'hAAAA_5555_CCCC_3333);
    op(1'b0, 2'd2, 8'd9, 1'b0, 64'd0, 64'd0);
    // R4 remaps, read back through plain selectors
    sreg_base = 7'd10; rsv_count = 7'd20;
    op(1'b1, 2'd2, 8'h60, 1'b0, 64'h0C0C_0C0C_0B0B_0B0B, 64'd0);
    op(1'b1, 2'd1, 8'h61, 1'b0, 64'h0000_0000_0777_0777, 64'd0);
    op(1'b1, 2'd1, 8'h62, 1'b1, 64'd0, 64'h0000_0000_0666_0666);
    op(1'b0, 2'd2, 8'd16, 1'b0, 64'd0, 64'd0);
    op(1'b0, 2'd2, 8'd18, 1'b0, 64'd0, 64'd0);
    op(1'b0, 2'd2, 8'h62, 1'b0, 64'd0, 64'd0);
    rsv_count = 7'd3;
    op(1'b0, 2'd1, 8'h62, 1'b0, 64'd0, 64'd0);
    op(1'b0, 2'd1, 8'h61, 1'b0, 64'd0, 64'd0);
    // R5/R6 exec halves
    op(1'b1, 2'd1, 8'h64, 1'b0, 64'hFFFF_FFFF_1234_5678, 64'd0);
    op(1'b1, 2'd1, 8'h65, 1'b0, 64'h0000_0000_9ABC_DEF0, 64'd0);
    op(1'b0, 2'd2, 8'h64, 1'b0, 64'd0, 64'd0);
    op(1'b1, 2'd2, 8'h64, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0, 64'd0);
    op(1'b0, 2'd1, 8'h65, 1'b0, 64'd0, 64'd0);
    op(1'b1, 2'd2, 8'h65, 1'b0, 64'h1, 64'd0);
    op(1'b1, 2'd3, 8'h64, 1'b0, 64'h2, 64'd0);
    // R7/R8 all constants, both widths
    for (int k = 0; k < 9; k++) begin
      op(1'b0, 2'd1, 8'h70 + 8'(k), 1'b0, 64'd0, 64'd0);
      op(1'b0, 2'd2, 8'h70 + 8'(k), 1'b0, 64'd0, 64'd0);
    end
    // R9 literal selectors
    lit_word = 32'hCAFE_F00D;
    for (int k = 0; k < 3; k++) begin
      op(1'b0, 2'd1, 8'h7C + 8'(k), 1'b0, 64'd0, 64'd0);
      op(1'b0, 2'd2, 8'h7C + 8'(k), 1'b0, 64'd0, 64'd0);
    end
    // R10 edge of storage, bad widths, writes to constants
    sreg_base = 7'd32;
    op(1'b0, 2'd1, 8'd95, 1'b0, 64'd0, 64'd0);
    op(1'b1, 2'd2, 8'd95, 1'b0, 64'h5, 64'd0);
    op(1'b0, 2'd0, 8'd0, 1'b0, 64'd0, 64'd0);
    op(1'b1, 2'd1, 8'h72, 1'b0, 64'h7, 64'd0);
    op(1'b0, 2'd1, 8'h6A, 1'b0, 64'd0, 64'd0);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] s;
      int c;
      if (i % 50 == 0) begin
        sreg_base = 7'($urandom_range(0, 40));
        rsv_count = 7'($urandom_range(0, 60));
        lit_word  = $urandom;
      end
      c = $urandom_range(0, 9);
      case (c)
        0, 1, 2, 3, 4: s = 8'($urandom_range(0, 95));
        5: s = 8'h60 + 8'($urandom_range(0, 2));
        6: s = 8'h64 + 8'($urandom_range(0, 1));
        7: s = 8'h70 + 8'($urandom_range(0, 8));
        8: s = 8'h7C + 8'($urandom_range(0, 2));
        default: s = 8'($urandom);
      endcase
      op(1'($urandom), ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'($urandom_range(1, 2)),
         s, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule